// File: doc/BRIEF.md
# PRBS31 Byte-Stream Pattern Source

This block produces the transmit side of a bit error rate test for a link that carries bytes. A 31-bit Galois shift register with feedback polynomial 1 + x^28 + x^31 holds the pattern state. Every word the block emits is the bitwise complement of that state, widened to 32 bits. The block then hands the word out one byte at a time on a valid/ready port. The far end runs the same register and compares what it receives against its own copy.

The register takes one step per word, not one step per bit, so neighbouring words overlap by all but one bit. A select input chooses which end of the word goes out first, so the two sides of the link can disagree on byte order and still match. An enable input pauses the stream at a byte boundary and loses no state. A guard keeps the register from ever holding zero, because the register would stay at zero once it got there.

Top module: `prbs31_byte_tx`

## Requirements
- R1: One register step shifts the 31-bit state right by one place. If the bit that leaves at position 0 was 1, the result is XORed with a mask that has bits 30 and 27 set; if that bit was 0, the shifted value is kept unchanged.
- R2: The 32-bit word is the bitwise complement of the 31-bit state after the state is widened with a zero in bit 31. Bit 31 of every word is therefore 1.
- R3: After reset the state is seeded with 1 and stepped once. The first word is therefore 0xB7FFFFFF.
- R4: The state advances exactly once per word. It advances in the cycle in which the fourth byte of the word is accepted (valid_o and ready_i both high), and it holds in every other cycle.
- R5: With order_i = 0 the bytes of a word go out from bits 7:0 up to bits 31:24. With order_i = 1 they go out from bits 31:24 down to bits 7:0. order_i is intended to change only between words.
- R6: The state is never zero. A SEED parameter of 0 is replaced by 1, so an instance built with SEED = 0 emits the same stream as one built with SEED = 1.
- R7: The byte index advances by one on each accepted byte and wraps after the fourth byte. While valid_o is high and ready_i is low, byte_o and the index hold.
- R8: valid_o is registered and equals en_i from the previous clock. While en_i is low no byte is accepted, the state and the byte index are kept, and the stream resumes with the next unsent byte.
- R9: Reset is synchronous and active high. It drives valid_o low, clears the byte index to 0 and reloads the seeded state, so the stream restarts with the R3 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; valid_o follows it one cycle later |
| order_i | input | 1 | Byte order: 0 sends the low byte first, 1 sends the high byte first |
| ready_i | input | 1 | Sink is ready to take byte_o |
| byte_o | output | 8 | Current pattern byte |
| valid_o | output | 1 | byte_o is offered |

## Verification
The zero-state guard is the hardest case to reach. A correctly seeded register never drifts into zero, so the guard can only be reached through the seed. The bench therefore runs a second instance built with SEED = 0 next to the main one and requires its bytes to match byte for byte. Dropping enable in the middle of a word is also awkward to reach, because valid_o lags en_i by a cycle. The stimulus clears ready_i for that lagging cycle, then keeps ready_i high with enable off, and then shows that the stream resumes with the unsent byte.

// File: rtl/prbs31_pkg.sv
package prbs31_pkg;

  localparam int unsigned LFSR_W    = 31;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned TAP_HI    = 30;
  localparam int unsigned TAP_LO    = 27;
  localparam int unsigned NUM_BYTES = WORD_W / BYTE_W;
  localparam int unsigned IDX_W     = $clog2(NUM_BYTES);

  localparam logic [LFSR_W-1:0] ONE_STATE = LFSR_W'(1);
  localparam logic [LFSR_W-1:0] TAP_MASK  = (ONE_STATE << TAP_HI) | (ONE_STATE << TAP_LO);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_BYTES - 1);

  typedef enum logic {
    ORDER_LOW_FIRST  = 1'b0,
    ORDER_HIGH_FIRST = 1'b1
  } byte_order_e;

  // One Galois step: right shift, fold the taps back in when a 1 leaves.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAP_MASK : '0);
  endfunction

  function automatic logic [WORD_W-1:0] state_to_word(input logic [LFSR_W-1:0] s);
    return ~(WORD_W'(s));
  endfunction

endpackage

// File: rtl/prbs31_state.sv
module prbs31_state
  import prbs31_pkg::*;
#(
  parameter int unsigned SEED = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              advance_i,
  output logic [LFSR_W-1:0] state_o
);

  // Zero seed would lock the register; substitute a legal one.
  localparam logic [LFSR_W-1:0] SEED_EFF =
    (LFSR_W'(SEED) == '0) ? ONE_STATE : LFSR_W'(SEED);
  // The first word is taken one step after seeding.
  localparam logic [LFSR_W-1:0] RESET_STATE = lfsr_step(SEED_EFF);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] stepped;
  logic [LFSR_W-1:0] load_val;

  always_comb begin
    stepped  = lfsr_step(state_q);
    load_val = (stepped == '0) ? SEED_EFF : stepped;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= RESET_STATE;
    end else if (advance_i) begin
      state_q <= load_val;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/prbs31_byte_index.sv
module prbs31_byte_index
  import prbs31_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      idx_q <= '0;
    end else if (take_i) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/prbs31_byte_pick.sv
module prbs31_byte_pick
  import prbs31_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  byte_order_e       order_i,
  output logic [BYTE_W-1:0] byte_o
);

  logic [BYTE_W-1:0] lane [NUM_BYTES];

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
    assign lane[k] = word_i[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (order_i == ORDER_HIGH_FIRST) begin
      byte_o = lane[LAST_IDX - idx_i];
    end else begin
      byte_o = lane[idx_i];
    end
  end

endmodule

// File: rtl/prbs31_byte_tx.sv
module prbs31_byte_tx
  import prbs31_pkg::*;
#(
  parameter int unsigned SEED = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              order_i,
  input  logic              ready_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);

  logic              valid_q;
  logic              take;
  logic              word_done;
  logic              last_byte;
  logic [LFSR_W-1:0] lfsr_state;
  logic [IDX_W-1:0]  byte_idx;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= en_i;
    end
  end

  assign take      = valid_q & ready_i;
  assign word_done = take & last_byte;
  assign word      = state_to_word(lfsr_state);

  prbs31_state #(
    .SEED(SEED)
  ) u_state (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .advance_i(word_done),
    .state_o  (lfsr_state)
  );

  prbs31_byte_index u_index (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .take_i(take),
    .idx_o (byte_idx),
    .last_o(last_byte)
  );

  prbs31_byte_pick u_pick (
    .word_i (word),
    .idx_i  (byte_idx),
    .order_i(byte_order_e'(order_i)),
    .byte_o (byte_o)
  );

  assign valid_o = valid_q;

endmodule

// File: rtl/prbs31_byte_tx_chk.sv
module prbs31_byte_tx_chk
  import prbs31_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic              en_i,
  input logic              order_i,
  input logic              ready_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic              valid_o,
  input logic [LFSR_W-1:0] lfsr_state,
  input logic [IDX_W-1:0]  byte_idx
);

  logic take;
  assign take = valid_o && ready_i;

  // R9: reset idles the port and rewinds the index
  a_r9_reset_idle: assert property (@(posedge clk_i)
    rst_i |=> (!valid_o && byte_idx == '0));

  // R8: valid follows enable by one cycle
  a_r8_valid_on: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> valid_o);
  a_r8_valid_off: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !valid_o);

  // R4, R1: state steps once when the last byte leaves
  a_r4_step_on_last: assert property (@(posedge clk_i) disable iff (rst_i)
    (take && byte_idx == LAST_IDX) |=> (lfsr_state == lfsr_step($past(lfsr_state))));
  a_r4_hold_otherwise: assert property (@(posedge clk_i) disable iff (rst_i)
    !(take && byte_idx == LAST_IDX) |=> $stable(lfsr_state));

  // R7: index moves on each accepted byte only
  a_r7_idx_step: assert property (@(posedge clk_i) disable iff (rst_i)
    take |=> (byte_idx == IDX_W'($past(byte_idx) + 1'b1)));
  a_r7_idx_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !take |=> $stable(byte_idx));
  a_r7_byte_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && !ready_i) |=> ($stable(byte_o) || !$stable(order_i)));

  // R6: register never sits at zero
  a_r6_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
    lfsr_state != '0);

endmodule

bind prbs31_byte_tx prbs31_byte_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .en_i      (en_i),
  .order_i   (order_i),
  .ready_i   (ready_i),
  .byte_o    (byte_o),
  .valid_o   (valid_o),
  .lfsr_state(lfsr_state),
  .byte_idx  (byte_idx)
);

// File: tb/prbs31_byte_tx_tb.sv
module prbs31_byte_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       order = 1'b0;
  logic       rdy = 1'b0;
  logic [7:0] byte_out;
  logic       valid;
  logic [7:0] byte_z;
  logic       valid_z;

  logic [7:0]  exp_q[$];
  logic [30:0] m_state;
  int n_chk = 0;
  int n_err = 0;
  int n_acc = 0;
  string phase_req = "R5";

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs31_byte_tx u_dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .order_i(order), .ready_i(rdy),
    .byte_o(byte_out), .valid_o(valid)
  );

  prbs31_byte_tx #(.SEED(0)) u_dut_z (
    .clk_i(clk), .rst_i(rst), .en_i(en), .order_i(order), .ready_i(rdy),
    .byte_o(byte_z), .valid_o(valid_z)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Reference model straight from R1/R2/R5
  function automatic logic [30:0] model_step(input logic [30:0] s);
    logic [30:0] r;
    r = s >> 1;
    if (s[0]) begin
      r[30] = ~r[30];
      r[27] = ~r[27];
    end
    return r;
  endfunction

  task automatic push_word(input logic ord);
    logic [31:0] w;
    m_state = model_step(m_state);
    w = ~{1'b0, m_state};
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(ord ? w[8*(3-k) +: 8] : w[8*k +: 8]);
    end
  endtask

  // Scoreboard monitor: sample mid-cycle, before the accepting edge
  always @(negedge clk) begin
    if (!rst && valid && rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected byte", int'(byte_out), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(byte_out == e, phase_req, int'(byte_out), int'(e));
      end
      check(byte_z == byte_out && valid_z == valid, "R6 zero-seed twin", int'(byte_z), int'(byte_out));
      n_acc++;
    end
  end

  // Driver: called just after a rising edge
  task automatic send(input int n, input int mode);
    int tgt;
    int cyc;
    tgt = n_acc + n;
    cyc = 0;
    while (n_acc < tgt) begin
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (cyc % 3) != 0;
        default: rdy = ($urandom % 2) == 1;
      endcase
      @(posedge clk); #1;
      cyc++;
    end
    rdy = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    m_state = 31'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(valid == 1'b0, "R9 valid low in reset", int'(valid), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    en = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(valid == 1'b1, "R8 valid after enable", int'(valid), 1);
    check(byte_out == 8'hFF, "R3 first byte low-first", int'(byte_out), 8'hFF);
    order = 1'b1;
    #1;
    check(byte_out == 8'hB7, "R2 R3 first byte high-first", int'(byte_out), 8'hB7);
    order = 1'b0;
    @(posedge clk); #1;

    // low byte first, back to back
    phase_req = "R1 R5 low-first stream";
    for (int i = 0; i < 8; i++) push_word(1'b0);
    send(32, 0);
    check(exp_q.size() == 0, "R4 words consumed", exp_q.size(), 0);

    // high byte first, gapped ready
    phase_req = "R5 high-first stream";
    order = 1'b1;
    for (int i = 0; i < 8; i++) push_word(1'b1);
    send(32, 1);
    check(exp_q.size() == 0, "R4 words consumed", exp_q.size(), 0);

    // stall mid-word
    order = 1'b0;
    phase_req = "R7 stall stream";
    for (int i = 0; i < 2; i++) push_word(1'b0);
    send(2, 0);
    repeat (5) begin
      @(negedge clk);
      check(byte_out == exp_q[0] && valid, "R7 byte held while stalled", int'(byte_out), int'(exp_q[0]));
      @(posedge clk); #1;
    end
    send(6, 2);

    // enable drop mid-word
    phase_req = "R8 resume stream";
    for (int i = 0; i < 2; i++) push_word(1'b0);
    send(3, 0);
    en = 1'b0;
    @(posedge clk); #1;
    rdy = 1'b1;
    begin
      int acc0;
      acc0 = n_acc;
      repeat (6) begin
        @(negedge clk);
        check(valid == 1'b0, "R8 valid low when disabled", int'(valid), 0);
        check(byte_out == exp_q[0], "R8 byte kept when disabled", int'(byte_out), int'(exp_q[0]));
        @(posedge clk); #1;
      end
      check(n_acc == acc0, "R8 no bytes taken when disabled", n_acc, acc0);
    end
    rdy = 1'b0;
    en = 1'b1;
    @(posedge clk); #1;
    send(5, 0);
    check(exp_q.size() == 0, "R4 words consumed", exp_q.size(), 0);

    // long runs, order fixed per batch
    phase_req = "R1 long stream";
    for (int b = 0; b < 4; b++) begin
      order = b[0];
      for (int i = 0; i < 60; i++) push_word(b[0]);
      send(240, 2);
    end
    check(exp_q.size() == 0, "R4 words consumed", exp_q.size(), 0);

    // reset in the middle of a word
    order = 1'b0;
    push_word(1'b0);
    send(2, 0);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    exp_q.delete();
    m_state = 31'd1;
    @(negedge clk);
    check(valid == 1'b0, "R9 valid low after reset", int'(valid), 0);
    @(posedge clk); #1;
    phase_req = "R9 restart stream";
    for (int i = 0; i < 3; i++) push_word(1'b0);
    @(negedge clk);
    check(byte_out == 8'hFF, "R9 restart at first word", int'(byte_out), 8'hFF);
    @(posedge clk); #1;
    send(12, 1);
    check(exp_q.size() == 0, "R4 words consumed", exp_q.size(), 0);

    finish_run();
  end

endmodule